// File: doc/BRIEF.md
# Self-Correcting Synchronous Decade Counter

A four-bit synchronous counter that steps through the decimal digits 0 to 9 and wraps back to 0. Each bit is a D flip-flop whose next value is a fixed XOR-form equation of the present bits. Nothing in the design detects the six codes 10 to 15. Because the equations are fixed, every one of those codes still has a defined successor, and each one comes back into the decimal range within two enabled clocks.

A count enable advances the digit. A terminal-count output is high while the digit is 9 and the enable is high, so the next stage of a multi-digit chain can use it as its enable. The design has a synchronous active-high reset. It also has a load path, so that any code, including an illegal one, can be placed in the register.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 on that edge. This holds whatever `ld` and `en` are doing, so reset takes priority over both.
- R2: With `en` high and `ld` low, each rising edge advances the count by one from 0 up to 8, and 9 is followed by 0.
- R3: With `en` low and `ld` low, the count keeps its value across the edge.
- R4: `tc` is high exactly when the count is 9 and `en` is high. It is combinational, with no register delay.
- R5: With `ld` high and `rst` low, the count takes `ld_val` at the edge, whether `en` is high or low.
- R6: Under an enabled step, the even illegal codes go 10→11, 12→13 and 14→15, and the odd illegal codes go 11→6, 13→4 and 15→2.
- R7: Starting from any code from 10 to 15, at most two enabled clocks bring the count to a value from 0 to 9.
- R8: The bit order of `count` is fixed: bit 3 has weight 8, bit 2 weight 4, bit 1 weight 2 and bit 0 weight 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0 |
| en | input | 1 | Count enable |
| ld | input | 1 | Load strobe for `ld_val` |
| ld_val | input | 4 | Value to load |
| count | output | 4 | Present digit, weights 8-4-2-1 |
| tc | output | 1 | Terminal count (digit 9 with enable) |

## Verification
Some behaviours are checked by assertions on every cycle: the wrap from 9 to 0, holding while disabled, the terminal-count relation, load priority, and the rule that an odd illegal code steps straight into the decimal range while an even one steps to an odd illegal code. Other behaviours can only be shown by the bench's scenarios. These are the exact successor of each of the sixteen codes, the full decimal sequence, the two-clock recovery path from each illegal code, and reset winning over a load at the same edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int DIGIT_W  = 4;
    localparam int DIGIT_MAX = 9;

    // Bit weights 8-4-2-1, MSB first
    typedef struct packed {
        logic w8;
        logic w4;
        logic w2;
        logic w1;
    } digit_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    // Fixed XOR-form next-state equations; illegal codes fall back by themselves
    function automatic digit_t step_digit(input digit_t d);
        digit_t n;
        n.w1 = ~d.w1;
        n.w2 = d.w2 ^ (d.w1 & ~d.w8);
        n.w4 = d.w4 ^ (d.w1 & d.w2);
        n.w8 = d.w8 ^ ((d.w1 & d.w8) | (d.w1 & d.w2 & d.w4));
        return n;
    endfunction

    function automatic logic is_decimal(input digit_t d);
        return (d <= digit_t'(DIGIT_MAX));
    endfunction

endpackage

// File: rtl/bcd_op_select.sv
module bcd_op_select
    import bcd_pkg::*;
(
    input  logic rst,
    input  logic ld,
    input  logic en,
    output op_e  op
);
    // Priority: reset, then load, then count enable
    always_comb begin
        if (rst)      op = OP_CLEAR;
        else if (ld)  op = OP_LOAD;
        else if (en)  op = OP_STEP;
        else          op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_next_state.sv
module bcd_next_state
    import bcd_pkg::*;
(
    input  digit_t cur,
    input  digit_t ld_val,
    input  op_e    op,
    output digit_t nxt
);
    digit_t stepped;

    always_comb stepped = step_digit(cur);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = ld_val;
            OP_STEP:  nxt = stepped;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                ld,
    input  logic [DIGIT_W-1:0]  ld_val,
    output logic [DIGIT_W-1:0]  count,
    output logic                tc
);
    op_e    op;
    digit_t state_q;
    digit_t state_d;

    bcd_op_select u_sel (
        .rst (rst),
        .ld  (ld),
        .en  (en),
        .op  (op)
    );

    bcd_next_state u_nxt (
        .cur    (state_q),
        .ld_val (digit_t'(ld_val)),
        .op     (op),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q;   // R8: bit 3 weight 8 ... bit 0 weight 1
    assign tc    = en && (state_q == digit_t'(DIGIT_MAX));

    // R1
    a_r1_clear: assert property (@(posedge clk) rst |=> count == '0);

    // R2
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (count == 4'd9 && en && !ld) |=> count == 4'd0);

    // R3
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !ld) |=> $stable(count));

    // R4
    a_r4_tc: assert property (@(posedge clk) disable iff (rst)
        tc |-> (count == 4'd9));

    // R5
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> count == $past(ld_val));

    // R6 / R7: odd illegal lands in range, even illegal moves to odd illegal
    a_r6_odd_illegal: assert property (@(posedge clk) disable iff (rst)
        (count > 4'd9 && count[0] && en && !ld) |=> count <= 4'd9);

    a_r7_even_illegal: assert property (@(posedge clk) disable iff (rst)
        (count > 4'd9 && !count[0] && en && !ld) |=> (count > 4'd9 && count[0]));

endmodule

// File: tb/sim_bcd_decade_counter.sv
module sim_bcd_decade_counter;

    logic       clk = 1'b0;
    logic       rst, en, ld;
    logic [3:0] ld_val;
    logic [3:0] count;
    logic       tc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Successor of each code under one enabled step (R2, R6)
    localparam logic [3:0] SUCC [16] = '{
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8,
        4'd9, 4'd0, 4'd11, 4'd6, 4'd13, 4'd4, 4'd15, 4'd2
    };

    always #2 clk = ~clk;   // 250 MHz

    bcd_decade_counter u0 (
        .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
        .count(count), .tc(tc)
    );

    task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive on falling edge, let one rising edge pass, sample just after it
    task automatic tick(input logic r, input logic e, input logic l, input logic [3:0] v);
        @(negedge clk);
        rst = r; en = e; ld = l; ld_val = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; ld = 1'b0; ld_val = '0;
        tick(1, 0, 0, 0);
        tick(1, 0, 0, 0);
        check4("R1 reset value", count, 4'd0);
        check1("R1 tc in reset", tc, 1'b0);

        // Successor table walk over all sixteen codes
        for (int v = 0; v < 16; v++) begin
            tick(0, 0, 1, 4'(v));
            check4("R5 load", count, 4'(v));
            tick(0, 1, 0, 0);
            check4(v > 9 ? "R6 illegal successor" : "R2 successor", count, SUCC[v]);
        end

        // Full decimal sequence from 0, with tc
        tick(1, 0, 0, 0);
        for (int i = 1; i <= 20; i++) begin
            tick(0, 1, 0, 0);
            check4("R2 sequence", count, 4'(i % 10));
            check1("R4 tc while enabled", tc, (i % 10) == 9);
        end

        // R4: count 9 with enable low gives no tc
        tick(0, 0, 1, 4'd9);
        check1("R4 tc low when disabled", tc, 1'b0);
        @(negedge clk); en = 1'b1; #1;
        check1("R4 tc combinational", tc, 1'b1);

        // R3: hold for several edges
        tick(0, 0, 1, 4'd7);
        for (int i = 0; i < 4; i++) begin
            tick(0, 0, 0, 0);
            check4("R3 hold", count, 4'd7);
        end

        // R5: load wins over enable
        tick(0, 1, 1, 4'd3);
        check4("R5 load over enable", count, 4'd3);

        // R1: reset wins over load
        tick(1, 1, 1, 4'd5);
        check4("R1 reset over load", count, 4'd0);

        // R7: each illegal code reaches the decimal range in at most two steps
        for (int v = 10; v < 16; v++) begin
            tick(0, 0, 1, 4'(v));
            tick(0, 1, 0, 0);
            if (count > 4'd9) tick(0, 1, 0, 0);
            checks++;
            if (count > 4'd9) begin
                errors++;
                $display("FAIL R7 recovery from %0d: got %0d expected <=9", v, count);
            end
        end

        // R8: weight-8 bit alone is eight
        tick(0, 0, 1, 4'b1000);
        check4("R8 bit weights", count, 4'd8);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule